// File: doc/BRIEF.md
# Li-ion Charge Cycle Sequencer

This block is the digital sequencer that steps a Li-ion charger through one charge cycle. It takes already-qualified comparator flags as inputs. These report a battery below the low-voltage level, a battery above the recharge level, charge current below the termination level, the enable input above its upper or below its lower level, battery overvoltage, and the die-temperature shutdown and release levels. A two-bit timer-mode select completes the inputs. From these flags the block decides whether the power stage runs, and whether it delivers the reduced precharge current (one tenth of the fast rate, set by the analog side) or the full fast-charge current. It also raises a timer-fault flag, turns on a small fault current, and drives an open-drain status transistor that is on, off or blinking.

All timing runs from a slow single-cycle `tick` strobe. The precharge watchdog, the fast-charge timer, the precharge/fast-charge deglitch window, the overvoltage persistence window and the blink half-period are parameters counted in ticks. Every time counter restarts from zero when the state changes. The block has no analog loops, no PWM stage and no thermistor zone logic.

Top module: `li_charge_seq`

## Requirements
- R1: While reset is held, and until the enable is first qualified, `chg_en`, `sel_fast`, `fault`, `flt_cur` and `stat_drv` are all 0.
- R2: The enable state is set by `en_hi`, cleared by `en_lo` (when `en_hi` is low) and otherwise held. When it is clear, the sequencer goes to the idle state (no charging, no fault) within two clocks, whatever state it was in. When it is set, a new cycle starts.
- R3: A cycle starts in precharge (`chg_en`=1, `sel_fast`=0) if `bat_lowv` is 1, and otherwise in fast charge (`chg_en`=1, `sel_fast`=1).
- R4: Precharge moves to fast charge only after `bat_lowv` has stayed 0 for DGL_TICKS ticks. Fast charge moves to precharge only after `bat_lowv` has stayed 1 for DGL_TICKS ticks. A shorter excursion changes nothing.
- R5: After PRE_TICKS ticks in precharge, charging stops and `fault` is set, whatever the timer mode.
- R6: The fast-charge timer (FAST_TICKS ticks, ending in a fault) runs only when `tmr_mode[1]`=1. Code 2'b00 disables it and termination. Code 2'b01 disables the timer only.
- R7: In fast charge with `tmr_mode`≠2'b00, `bat_rech`=1 together with `ichg_term`=1 ends the cycle: `chg_en`=0 and `stat_drv`=0. A new cycle starts when `bat_rech` returns to 0.
- R8: A timeout with `bat_rech`=1 gives a fault that clears, and restarts a cycle, once `bat_rech` falls to 0. A timeout with `bat_rech`=0 gives a fault with `flt_cur`=1 until `bat_rech` rises, after which the first path applies.
- R9: `bat_ov` held for OV_TICKS ticks while charging suspends charging without `fault`. A cycle restarts when `bat_ov` clears.
- R10: `tj_hot` while charging stops charging on the next clock. A cycle restarts only when `tj_cool` is 1.
- R11: `stat_drv` is 1 while charging, 0 when idle or done, and blinks in fault, overvoltage and thermal suspend. In those states it starts at 0 on entry and toggles every BLINK_TICKS ticks.
- R12: Time counters restart on every state change, so each timeout and deglitch window is measured from the entry into the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow time-base strobe, one clock wide |
| en_hi | input | 1 | Enable input above upper level |
| en_lo | input | 1 | Enable input below lower level |
| bat_lowv | input | 1 | Battery below low-voltage level |
| bat_rech | input | 1 | Battery above recharge level |
| ichg_term | input | 1 | Charge current below termination level |
| bat_ov | input | 1 | Battery overvoltage |
| tj_hot | input | 1 | Die above shutdown temperature |
| tj_cool | input | 1 | Die below restart temperature |
| tmr_mode | input | 2 | 00 no timer/no termination, 01 no timer, 1x timer on |
| chg_en | output | 1 | Power stage enable |
| sel_fast | output | 1 | 1 fast-charge current, 0 precharge current |
| fault | output | 1 | Timer fault |
| flt_cur | output | 1 | Small fault current enable |
| stat_drv | output | 1 | Status open-drain transistor on |

## Verification
The assertions assume that every input flag is synchronous to `clk`, that `tick` is at most one clock wide, and that `en_hi` and `en_lo` are never both 1. The bench changes every input on the falling edge, issues `tick` as a one-clock pulse every fourth clock, and never raises both enable levels together. Flag excursions shorter than the deglitch and overvoltage windows are applied on purpose, next to excursions that last long enough to take effect.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PRE    = 3'd1,
    ST_FAST   = 3'd2,
    ST_DONE   = 3'd3,
    ST_FLT_HI = 3'd4,
    ST_FLT_LO = 3'd5,
    ST_OVP    = 3'd6,
    ST_HOT    = 3'd7
  } seq_state_t;
endpackage

// File: rtl/lcs_rst_sync.sv
module lcs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rs_n
);
  logic s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= 1'b0;
      rs_n <= 1'b0;
    end else begin
      s1   <= 1'b1;
      rs_n <= s1;
    end
  end
endmodule

// File: rtl/lcs_counter.sv
module lcs_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rs_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (clr) q_d = '0;
    else if (inc && (q != TOP)) q_d = q + 1'b1;
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) q <= '0;
    else       q <= q_d;
  end
endmodule

// File: rtl/lcs_blink.sv
module lcs_blink #(
  parameter int unsigned HALF = 4
) (
  input  logic clk,
  input  logic rs_n,
  input  logic clr,
  input  logic tick,
  output logic ph
);
  localparam int unsigned W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [W-1:0] LAST = W'(HALF - 1);
  logic [W-1:0] cnt, cnt_d;
  logic         ph_d;

  always_comb begin
    cnt_d = cnt;
    ph_d  = ph;
    if (clr) begin
      cnt_d = '0;
      ph_d  = 1'b0;
    end else if (tick) begin
      if (cnt == LAST) begin
        cnt_d = '0;
        ph_d  = ~ph;
      end else begin
        cnt_d = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      cnt <= '0;
      ph  <= 1'b0;
    end else begin
      cnt <= cnt_d;
      ph  <= ph_d;
    end
  end
endmodule

// File: rtl/li_charge_seq.sv
module li_charge_seq
  import lcs_pkg::*;
#(
  parameter int unsigned PRE_TICKS   = 1800000,
  parameter int unsigned FAST_TICKS  = 18000000,
  parameter int unsigned DGL_TICKS   = 25,
  parameter int unsigned OV_TICKS    = 30,
  parameter int unsigned BLINK_TICKS = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en_hi,
  input  logic       en_lo,
  input  logic       bat_lowv,
  input  logic       bat_rech,
  input  logic       ichg_term,
  input  logic       bat_ov,
  input  logic       tj_hot,
  input  logic       tj_cool,
  input  logic [1:0] tmr_mode,
  output logic       chg_en,
  output logic       sel_fast,
  output logic       fault,
  output logic       flt_cur,
  output logic       stat_drv
);
  localparam int unsigned LA = (PRE_TICKS > FAST_TICKS) ? PRE_TICKS : FAST_TICKS;
  localparam int unsigned LB = (DGL_TICKS > OV_TICKS) ? DGL_TICKS : OV_TICKS;
  localparam int unsigned LM = (LA > LB) ? LA : LB;
  localparam int unsigned CW = $clog2(LM + 1);
  localparam logic [CW-1:0] PRE_LIM  = CW'(PRE_TICKS);
  localparam logic [CW-1:0] FAST_LIM = CW'(FAST_TICKS);
  localparam logic [CW-1:0] DGL_LIM  = CW'(DGL_TICKS);
  localparam logic [CW-1:0] OV_LIM   = CW'(OV_TICKS);

  logic          rs_n;
  seq_state_t    st, nxt, start_st;
  logic          en_q, en_d;
  logic [CW-1:0] dwell, dg, ovc;
  logic          chg, charging, dg_cond, dg_hit, ov_hit, tmo_hit, term_hit;
  logic          timer_on, term_on, blink_ph, blinking;

  lcs_rst_sync u_rs (.clk(clk), .rst_n(rst_n), .rs_n(rs_n));

  assign charging = (st == ST_PRE) || (st == ST_FAST);
  assign blinking = (st == ST_FLT_HI) || (st == ST_FLT_LO) || (st == ST_OVP) || (st == ST_HOT);
  assign timer_on = tmr_mode[1];
  assign term_on  = |tmr_mode;
  assign dg_cond  = (st == ST_PRE) ? ~bat_lowv : ((st == ST_FAST) ? bat_lowv : 1'b0);
  assign dg_hit   = dg_cond && (dg >= DGL_LIM);
  assign ov_hit   = bat_ov && (ovc >= OV_LIM);
  assign tmo_hit  = ((st == ST_PRE) && (dwell >= PRE_LIM)) ||
                    ((st == ST_FAST) && timer_on && (dwell >= FAST_LIM));
  assign term_hit = (st == ST_FAST) && term_on && bat_rech && ichg_term;
  assign start_st = bat_lowv ? ST_PRE : ST_FAST;
  assign chg      = (nxt != st);

  // enable hysteresis
  always_comb begin
    en_d = en_q;
    if (en_hi)      en_d = 1'b1;
    else if (en_lo) en_d = 1'b0;
  end

  always_comb begin
    nxt = st;
    if (!en_q) begin
      nxt = ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: nxt = start_st;
        ST_PRE, ST_FAST: begin
          if (tj_hot)        nxt = ST_HOT;
          else if (ov_hit)   nxt = ST_OVP;
          else if (tmo_hit)  nxt = bat_rech ? ST_FLT_HI : ST_FLT_LO;
          else if (term_hit) nxt = ST_DONE;
          else if (dg_hit)   nxt = (st == ST_PRE) ? ST_FAST : ST_PRE;
        end
        ST_DONE, ST_FLT_HI: if (!bat_rech) nxt = start_st;
        ST_FLT_LO:          if (bat_rech)  nxt = ST_FLT_HI;
        ST_OVP:             if (!bat_ov)   nxt = start_st;
        ST_HOT:             if (tj_cool)   nxt = start_st;
        default:            nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      st   <= ST_IDLE;
      en_q <= 1'b0;
    end else begin
      st   <= nxt;
      en_q <= en_d;
    end
  end

  lcs_counter #(.W(CW)) u_dwell (
    .clk(clk), .rs_n(rs_n), .clr(chg), .inc(tick), .q(dwell));
  lcs_counter #(.W(CW)) u_dgl (
    .clk(clk), .rs_n(rs_n), .clr(chg || !dg_cond), .inc(tick), .q(dg));
  lcs_counter #(.W(CW)) u_ovc (
    .clk(clk), .rs_n(rs_n), .clr(chg || !bat_ov || !charging), .inc(tick), .q(ovc));
  lcs_blink #(.HALF(BLINK_TICKS)) u_blink (
    .clk(clk), .rs_n(rs_n), .clr(chg), .tick(tick), .ph(blink_ph));

  assign chg_en   = charging;
  assign sel_fast = (st == ST_FAST);
  assign fault    = (st == ST_FLT_HI) || (st == ST_FLT_LO);
  assign flt_cur  = (st == ST_FLT_LO);
  assign stat_drv = charging | (blinking & blink_ph);

  assert_disable_R2: assert property (@(posedge clk) disable iff (!rs_n)
    (en_lo && !en_hi) |-> ##2 !chg_en);

  assert_deglitch_R4: assert property (@(posedge clk) disable iff (!rs_n)
    ($rose(sel_fast) && chg_en && $past(chg_en)) |-> $past(!bat_lowv));

  // R5 / R6: a timer fault is only entered from a charging state
  assert_fault_src_R5: assert property (@(posedge clk) disable iff (!rs_n)
    $rose(fault) |-> $past(chg_en));

  assert_thermal_R10: assert property (@(posedge clk) disable iff (!rs_n)
    (tj_hot && chg_en) |=> !chg_en);

  assert_blink_R11: assert property (@(posedge clk) disable iff (!rs_n)
    ((st == $past(st)) && blinking && !$stable(stat_drv)) |-> $past(tick));
endmodule

// File: tb/li_charge_seq_test.sv
module li_charge_seq_test;
  localparam int PRE = 40, FST = 60, DGL = 5, OVT = 6, BLK = 3;
  localparam int S_IDLE = 0, S_PRE = 1, S_FAST = 2, S_DONE = 3,
                 S_FHI = 4, S_FLO = 5, S_OVP = 6, S_HOT = 7;

  logic clk = 1'b0;
  logic rst_n, tick, en_hi, en_lo, bat_lowv, bat_rech, ichg_term, bat_ov, tj_hot, tj_cool;
  logic [1:0] tmr_mode;
  logic chg_en, sel_fast, fault, flt_cur, stat_drv;

  int checks = 0, failures = 0, cyc = 0, tcnt = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  li_charge_seq #(.PRE_TICKS(PRE), .FAST_TICKS(FST), .DGL_TICKS(DGL),
                  .OV_TICKS(OVT), .BLINK_TICKS(BLK)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en_hi(en_hi), .en_lo(en_lo),
    .bat_lowv(bat_lowv), .bat_rech(bat_rech), .ichg_term(ichg_term), .bat_ov(bat_ov),
    .tj_hot(tj_hot), .tj_cool(tj_cool), .tmr_mode(tmr_mode), .chg_en(chg_en),
    .sel_fast(sel_fast), .fault(fault), .flt_cur(flt_cur), .stat_drv(stat_drv));

  // tick every fourth clock
  always @(negedge clk) begin
    tcnt <= (tcnt == 3) ? 0 : tcnt + 1;
    tick <= (tcnt == 3);
  end

  // behavioural reference
  int m_st, m_dw, m_dg, m_ov, m_bc;
  bit m_en, m_ph, m_r1, m_r2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = S_IDLE; m_dw = 0; m_dg = 0; m_ov = 0; m_bc = 0;
      m_en = 0; m_ph = 0; m_r1 = 0; m_r2 = 0;
    end else if (!m_r2) begin
      m_r2 = m_r1; m_r1 = 1;
    end else begin
      int n, start;
      bit dgc, chg, chgst;
      start = bat_lowv ? S_PRE : S_FAST;
      chgst = (m_st == S_PRE || m_st == S_FAST);
      dgc = (m_st == S_PRE) ? !bat_lowv : (m_st == S_FAST) ? bat_lowv : 0;
      n = m_st;
      if (!m_en) n = S_IDLE;
      else if (m_st == S_IDLE) n = start;
      else if (chgst) begin
        if (tj_hot) n = S_HOT;
        else if (bat_ov && m_ov >= OVT) n = S_OVP;
        else if ((m_st == S_PRE && m_dw >= PRE) || (m_st == S_FAST && tmr_mode[1] && m_dw >= FST))
          n = bat_rech ? S_FHI : S_FLO;
        else if (m_st == S_FAST && tmr_mode != 0 && bat_rech && ichg_term) n = S_DONE;
        else if (dgc && m_dg >= DGL) n = (m_st == S_PRE) ? S_FAST : S_PRE;
      end
      else if ((m_st == S_DONE || m_st == S_FHI) && !bat_rech) n = start;
      else if (m_st == S_FLO && bat_rech) n = S_FHI;
      else if (m_st == S_OVP && !bat_ov) n = start;
      else if (m_st == S_HOT && tj_cool) n = start;
      chg = (n != m_st);
      m_dw = chg ? 0 : m_dw + tick;
      m_dg = (chg || !dgc) ? 0 : m_dg + tick;
      m_ov = (chg || !bat_ov || !chgst) ? 0 : m_ov + tick;
      if (chg) begin m_bc = 0; m_ph = 0; end
      else if (tick) begin
        if (m_bc == BLK - 1) begin m_bc = 0; m_ph = !m_ph; end
        else m_bc = m_bc + 1;
      end
      if (en_hi) m_en = 1; else if (en_lo) m_en = 0;
      m_st = n;
    end
  end

  function automatic logic [4:0] model_out();
    bit ch, bl;
    ch = (m_st == S_PRE || m_st == S_FAST);
    bl = (m_st >= S_FHI);
    return {ch, m_st == S_FAST, m_st == S_FHI || m_st == S_FLO, m_st == S_FLO, ch | (bl & m_ph)};
  endfunction

  // per-clock comparison against the reference
  always @(negedge clk) begin
    logic [4:0] got, exp;
    got = {chg_en, sel_fast, fault, flt_cur, stat_drv};
    exp = model_out();
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s cycle %0d outputs got=%b exp=%b", tag, cyc, got, exp);
    end
    cyc++;
  end

  task automatic chk(input string req, input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got=%b exp=%b", req, what, got, exp);
    end
  endtask

  task automatic cyc_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tk_wait(input int n);
    cyc_wait(4 * n);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; en_hi = 0; en_lo = 1; bat_lowv = 1; bat_rech = 0; ichg_term = 0;
    bat_ov = 0; tj_hot = 0; tj_cool = 1; tmr_mode = 2'b10;
    cyc_wait(3);
    chk("R1", chg_en, 0, "chg_en in reset");
    chk("R1", stat_drv, 0, "stat in reset");
    rst_n = 1;
    cyc_wait(6);
    chk("R1", chg_en, 0, "chg_en before enable");
    chk("R1", fault, 0, "fault before enable");

    tag = "R2"; en_hi = 1; en_lo = 0; cyc_wait(1); en_hi = 0;
    cyc_wait(4);
    chk("R2", chg_en, 1, "charging after enable");
    tag = "R3";
    chk("R3", sel_fast, 0, "precharge start with low battery");

    tag = "R4"; bat_lowv = 0; tk_wait(2); bat_lowv = 1; tk_wait(2);
    chk("R4", sel_fast, 0, "short excursion ignored");
    bat_lowv = 0; tk_wait(DGL + 3);
    chk("R4", sel_fast, 1, "fast after deglitch");

    tag = "R6"; tmr_mode = 2'b00; bat_rech = 1; ichg_term = 1; tk_wait(4);
    chk("R6", chg_en, 1, "mode 00 ignores termination");
    tag = "R7"; tmr_mode = 2'b01; cyc_wait(3);
    chk("R7", chg_en, 0, "terminated");
    chk("R7", stat_drv, 0, "status off when done");
    bat_rech = 0; ichg_term = 0; cyc_wait(3);
    chk("R7", sel_fast, 1, "recharge cycle in fast");

    tag = "R12"; bat_rech = 1; tmr_mode = 2'b10; tk_wait(FST - 3);
    chk("R12", fault, 0, "fast timer counts from entry");
    tag = "R6"; tk_wait(6);
    chk("R6", fault, 1, "fast timeout fault");
    tag = "R11"; tk_wait(2 * BLK + 1);
    chk("R8", flt_cur, 0, "no fault current above recharge");
    tag = "R8"; bat_rech = 0; cyc_wait(3);
    chk("R8", fault, 0, "fault cleared below recharge");
    chk("R8", chg_en, 1, "cycle restarted");

    tag = "R4"; bat_lowv = 1; tk_wait(DGL + 3);
    chk("R4", sel_fast, 0, "back to precharge after deglitch");
    tag = "R5"; tk_wait(PRE + 2);
    chk("R5", fault, 1, "precharge timeout");
    chk("R8", flt_cur, 1, "fault current below recharge");
    tag = "R8"; bat_rech = 1; cyc_wait(3);
    chk("R8", flt_cur, 0, "fault current off above recharge");
    chk("R8", fault, 1, "fault held above recharge");

    tag = "R2"; en_lo = 1; cyc_wait(1); en_lo = 0; cyc_wait(3);
    chk("R2", fault, 0, "disable clears fault");
    cyc_wait(5);
    chk("R2", chg_en, 0, "stays idle with no level");
    bat_lowv = 0; en_hi = 1; cyc_wait(1); en_hi = 0; cyc_wait(3);
    chk("R3", sel_fast, 1, "fast start with good battery");

    tag = "R9"; bat_rech = 0; bat_ov = 1; tk_wait(3); bat_ov = 0; tk_wait(1);
    chk("R9", chg_en, 1, "short overvoltage ignored");
    bat_ov = 1; tk_wait(OVT + 3);
    chk("R9", chg_en, 0, "overvoltage suspend");
    chk("R9", fault, 0, "no timer fault on overvoltage");
    bat_ov = 0; cyc_wait(3);
    chk("R9", chg_en, 1, "resume after overvoltage");

    tag = "R10"; tj_hot = 1; tj_cool = 0; cyc_wait(2);
    chk("R10", chg_en, 0, "thermal shutdown");
    tj_hot = 0; tk_wait(4);
    chk("R10", chg_en, 0, "held off until cool");
    tj_cool = 1; cyc_wait(3);
    chk("R10", chg_en, 1, "restart when cool");
    cyc_wait(8);
    finish_run();
  end
endmodule